// File: doc/BRIEF.md
# Parallel-to-Serial Display Link Transmitter

This block turns one 28-bit pixel word per pixel-clock period into four serial data streams and a forwarded clock stream. Each stream carries seven bits per pixel period. The word holds three 8-bit colour channels, line sync, frame sync, data enable and one spare control bit. The block runs entirely on the 7x bit clock, which is assumed to come from an external PLL that is phase-locked to the pixel clock. The pixel clock enters as a sampled input. The block watches it for the selected capture edge and takes the word on the bit-clock cycle in which that edge is first seen.

A strap-style input picks the capture edge. High selects the rising edge; low selects the falling edge, which is the default. A narrow mode drives only three data lanes with the low 21 bits. A power-down input silences every output and clears all held state. Differential drivers and the PLL lie outside the block.

Top module: `pxl_link_tx`

## Requirements
- R1: While `rst_n` is low, and after reset until the first capture, every data lane and the clock lane read 0.
- R2: Data lane n sends word bits 7n through 7n+6, lowest index first, one bit per bit-clock cycle, so seven bits per pixel period. All seven bits of a frame come from the same captured word.
- R3: The clock lane sends 1,1,0,0,0,1,1 over the seven slots of each frame. Its first slot lines up with bit 7n of each data lane.
- R4: A word is captured on the bit-clock edge at which the selected pixel-clock transition is first sampled. Its slot-0 bits appear on the outputs after the next bit-clock edge, and not earlier.
- R5: With `edge_rise_sel` = 1 only low-to-high pixel-clock transitions capture. With it at 0 only high-to-low transitions capture. The opposite transition captures nothing.
- R6: While `pwr_dn` is high, all lane outputs are 0 from the bit-clock edge after it is sampled, and all captured and shifting state is discarded.
- R7: After `pwr_dn` falls, the pixel clock level is first sampled for one bit-clock edge. No capture happens on that edge. Output resumes only with the first word captured after it.
- R8: With `narrow_mode` = 1 at capture time, word bits 27..21 are ignored and data lane 3 sends 0 for that frame.
- R9: If no capture edge arrives, every lane reads 0 once the current frame's seven slots are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | 7x bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled as data |
| edge_rise_sel | input | 1 | 1: capture on rising pixel edge, 0: falling |
| pwr_dn | input | 1 | Power-down, active high |
| narrow_mode | input | 1 | 1: three-lane 21-bit mode |
| pix_word | input | 28 | Parallel pixel colour and control word |
| lane_o | output | 4 | Serial data lanes, bit n is lane n |
| clk_lane_o | output | 1 | Forwarded clock lane |

## Verification
The bench targets the capture latency. It checks that slot 0 appears exactly two bit-clock cycles after the pixel edge is driven, because a design off by one stage would shift every lane by a bit. It gives an edge of the wrong polarity and expects silence; a decoder with inverted sense would emit a frame there. It releases power-down on the same cycle as a falling pixel transition. A design that kept a stale pixel-clock sample would capture a word there that should never be sent. In narrow mode it feeds words with the upper seven bits set, which would appear on lane 3 if the masking were missing. It also checks that the lanes drain to zero after a lone frame.

// File: rtl/dlt_pkg.sv
// Shared constants for the display link transmitter.
// Assumes a fixed 7:1 serialisation ratio set by LANE_BITS.
package dlt_pkg;
    localparam int LANE_BITS    = 7;
    localparam int DATA_LANES   = 4;
    localparam int NARROW_LANES = 3;
    localparam int WORD_W       = LANE_BITS * DATA_LANES;
    localparam int NARROW_W     = LANE_BITS * NARROW_LANES;
    // bit i is sent in slot i of each frame
    localparam logic [LANE_BITS-1:0] CLK_PATTERN = 7'b1100011;
endpackage

// File: rtl/dlt_capture.sv
// Edge capture: samples the pixel clock on the bit clock, detects the
// selected transition and latches the (optionally narrowed) word.
// Assumes the word is stable across the selected pixel edge. load_o pulses
// one bit-clock after capture, marking the first slot of a frame.
module dlt_capture #(
    parameter int WORD_W   = 28,
    parameter int NARROW_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_clk,
    input  logic              rise_sel,
    input  logic              pd_i,
    input  logic              narrow_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] hold_o,
    output logic              load_o
);
    localparam logic [WORD_W-1:0] NARROW_MASK =
        {{(WORD_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic px_q;
    logic armed;
    logic cap;
    logic rise_seen;
    logic fall_seen;

    // Decode the selected pixel transition, only once a valid prior sample exists.
    always_comb begin
        rise_seen = pix_clk & ~px_q;
        fall_seen = ~pix_clk & px_q;
        cap       = armed & ~pd_i & (rise_sel ? rise_seen : fall_seen);
    end

    // Track the pixel clock, arm after reset/power-down, latch the word.
    always_ff @(posedge clk) begin
        if (!rst_n || pd_i) begin
            px_q   <= 1'b0;
            armed  <= 1'b0;
            load_o <= 1'b0;
            hold_o <= '0;
        end else begin
            px_q   <= pix_clk;
            armed  <= 1'b1;
            load_o <= cap;
            if (cap) begin
                hold_o <= narrow_i ? (word_i & NARROW_MASK) : word_i;
            end
        end
    end

    // R7: no capture on the release edge of power-down
    p_cap_after_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> (!pd_i && !$past(pd_i)));

    // R8: narrow capture clears the upper lane's bits
    p_narrow_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && narrow_i) |=> (hold_o[WORD_W-1:NARROW_W] == '0));
endmodule

// File: rtl/dlt_lane_shifter.sv
// One serial lane: loads a parallel slice on load_i and shifts it out
// lowest bit first, filling with zeros. Power-down clears it.
module dlt_lane_shifter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pd_i,
    input  logic         load_i,
    input  logic [W-1:0] par_i,
    output logic         ser_o
);
    logic [W-1:0] sh;

    // Load a new frame or shift the current one towards bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || pd_i) begin
            sh <= '0;
        end else if (load_i) begin
            sh <= par_i;
        end else begin
            sh <= {1'b0, sh[W-1:1]};
        end
    end

    assign ser_o = sh[0];

    // R6: power-down silences the lane on the next edge
    p_pd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pd_i |=> !ser_o);

    // R4: slot 0 of the loaded slice appears right after the load edge
    p_first_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !pd_i) |=> (ser_o == $past(par_i[0])));
endmodule

// File: rtl/pxl_link_tx.sv
// Parallel-to-serial display link transmitter top. One capture stage feeds
// DATA_LANES data shifters and one clock-lane shifter. All logic runs on
// the bit clock, which is assumed to run at LANE_BITS times the pixel clock.
module pxl_link_tx
    import dlt_pkg::*;
#(
    parameter int LB = LANE_BITS,
    parameter int NL = DATA_LANES,
    parameter int NN = NARROW_LANES
) (
    input  logic            clk_bit,
    input  logic            rst_n,
    input  logic            pix_clk,
    input  logic            edge_rise_sel,
    input  logic            pwr_dn,
    input  logic            narrow_mode,
    input  logic [LB*NL-1:0] pix_word,
    output logic [NL-1:0]   lane_o,
    output logic            clk_lane_o
);
    localparam int WW = LB * NL;
    localparam int NW = LB * NN;

    logic [WW-1:0] hold;
    logic          load;

    dlt_capture #(.WORD_W(WW), .NARROW_W(NW)) u_cap (
        .clk      (clk_bit),
        .rst_n    (rst_n),
        .pix_clk  (pix_clk),
        .rise_sel (edge_rise_sel),
        .pd_i     (pwr_dn),
        .narrow_i (narrow_mode),
        .word_i   (pix_word),
        .hold_o   (hold),
        .load_o   (load)
    );

    // One shifter per data lane, each taking its own slice of the word.
    for (genvar n = 0; n < NL; n++) begin : g_lane
        dlt_lane_shifter #(.W(LB)) u_sh (
            .clk    (clk_bit),
            .rst_n  (rst_n),
            .pd_i   (pwr_dn),
            .load_i (load),
            .par_i  (hold[n*LB +: LB]),
            .ser_o  (lane_o[n])
        );
    end

    dlt_lane_shifter #(.W(LB)) u_clk_sh (
        .clk    (clk_bit),
        .rst_n  (rst_n),
        .pd_i   (pwr_dn),
        .load_i (load),
        .par_i  (CLK_PATTERN),
        .ser_o  (clk_lane_o)
    );

    // R3: every frame opens with a high clock-lane slot
    p_clk_frame_start_r3: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (load && !pwr_dn) |=> clk_lane_o);

    // R1: nothing leaves the block during reset
    p_reset_quiet_r1: assert property (@(posedge clk_bit)
        !rst_n |=> (lane_o == '0 && !clk_lane_o));
endmodule

// File: tb/pxl_link_tx_bench.sv
module pxl_link_tx_bench;
    localparam int LB = 7;
    localparam int NL = 4;
    localparam logic [6:0] PAT = 7'b1100011;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix = 1'b0;
    logic          sel = 1'b0;
    logic          pd = 1'b0;
    logic          narrow = 1'b0;
    logic [27:0]   word = '0;
    logic [NL-1:0] lane;
    logic          clk_lane;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase_req = "R1";

    always #4 clk = ~clk;

    pxl_link_tx u_pxl_link_tx (
        .clk_bit(clk), .rst_n(rst_n), .pix_clk(pix), .edge_rise_sel(sel),
        .pwr_dn(pd), .narrow_mode(narrow), .pix_word(word),
        .lane_o(lane), .clk_lane_o(clk_lane)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: pending capture, frame slot index, current word.
    bit        m_prev, m_arm, m_pend_v;
    int        m_idx = -1;
    logic [27:0] m_cur, m_pend;
    logic [NL-1:0] e_lane = '0;
    logic      e_clk = 1'b0;

    always @(posedge clk) begin
        if (!rst_n || pd) begin
            m_prev = 0; m_arm = 0; m_pend_v = 0; m_idx = -1; m_cur = '0;
        end else begin
            if (m_pend_v) begin
                m_cur = m_pend; m_idx = 0;
            end else if (m_idx >= 0 && m_idx < 6) m_idx++;
            else m_idx = -1;
            m_pend_v = m_arm && (sel ? (pix && !m_prev) : (!pix && m_prev));
            if (m_pend_v) begin
                m_pend = word;
                if (narrow) m_pend[27:21] = '0;
            end
            m_prev = pix; m_arm = 1;
        end
        for (int n = 0; n < NL; n++) e_lane[n] = (m_idx >= 0) ? m_cur[n*LB + m_idx] : 1'b0;
        e_clk = (m_idx >= 0) ? PAT[m_idx] : 1'b0;
    end

    // Compare the design against the reference on every cycle.
    always @(negedge clk) begin
        if (!done) begin
            for (int n = 0; n < NL; n++)
                chk(lane[n] == e_lane[n], (n == 3 && narrow) ? "R8" : "R2",
                    $sformatf("lane%0d [%s]", n, phase_req), lane[n], e_lane[n]);
            chk(clk_lane == e_clk, "R3", $sformatf("clock lane [%s]", phase_req),
                clk_lane, e_clk);
        end
    end

    task automatic run_free(input int cycles);
        int ph = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            ph = (ph == 6) ? 0 : ph + 1;
            pix = (ph < 4);
            if (ph == 2) word = $urandom;
        end
    endtask

    // One isolated capture: quiet gap, selected transition, then read 7 slots.
    task automatic lone_frame(input logic [27:0] w, input bit rise, input bit nar);
        logic [27:0] got = '0;
        logic [6:0]  ck = '0;
        logic [27:0] ew;
        sel = rise; narrow = nar; word = w;
        pix = rise ? 1'b0 : 1'b1;
        repeat (9) @(negedge clk);
        pix = ~pix;
        @(negedge clk);
        chk(lane == '0 && !clk_lane, "R4", "output before slot 0", {lane, clk_lane}, 0);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            for (int n = 0; n < NL; n++) got[n*LB + i] = lane[n];
            ck[i] = clk_lane;
        end
        ew = w;
        if (nar) ew[27:21] = '0;
        chk(got[20:0] == ew[20:0], "R2", "reassembled lanes 0..2", got[20:0], ew[20:0]);
        chk(got[27:21] == ew[27:21], nar ? "R8" : "R2", "reassembled lane 3",
            got[27:21], ew[27:21]);
        chk(ck == PAT, "R3", "clock lane frame", ck, PAT);
        chk(got[0] == w[0], rise ? "R5" : "R4", "slot 0 timing", got[0], w[0]);
        @(negedge clk);
        chk(lane == '0 && !clk_lane, "R9", "drain after lone frame", {lane, clk_lane}, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(lane == '0 && !clk_lane, "R1", "reset outputs", {lane, clk_lane}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(lane == '0 && !clk_lane, "R1", "idle after reset", {lane, clk_lane}, 0);

        phase_req = "R2";
        run_free(400);
        phase_req = "R4";
        lone_frame(28'h9A5_3C71, 1'b0, 1'b0);
        lone_frame(28'h0000_001, 1'b0, 1'b0);
        phase_req = "R5";
        lone_frame(28'hF0F_0F0F, 1'b1, 1'b0);
        // wrong polarity: falling transition with rising selected
        sel = 1'b1; pix = 1'b1; word = 28'hFFF_FFFF;
        repeat (9) @(negedge clk);
        pix = 1'b0;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            chk(lane == '0 && !clk_lane, "R5", "opposite edge ignored", {lane, clk_lane}, 0);
        end
        sel = 1'b1;
        run_free(300);

        phase_req = "R8";
        narrow = 1'b1;
        lone_frame(28'hFE0_0000 | 28'h1F_FFFF, 1'b0, 1'b1);
        sel = 1'b0;
        run_free(300);
        narrow = 1'b0;

        phase_req = "R6";
        run_free(40);
        pd = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            pix = ~pix;
            chk(lane == '0 && !clk_lane, "R6", "power-down quiet", {lane, clk_lane}, 0);
        end
        // release on the same cycle as a falling transition: must not capture
        phase_req = "R7";
        sel = 1'b0; pix = 1'b1; word = 28'hABC_DEF1;
        repeat (3) @(negedge clk);
        pd = 1'b0; pix = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(lane == '0 && !clk_lane, "R7", "no capture on release", {lane, clk_lane}, 0);
        end
        lone_frame(28'h135_7924, 1'b0, 1'b0);
        run_free(300);

        phase_req = "R1";
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(lane == '0 && !clk_lane, "R1", "mid-run reset", {lane, clk_lane}, 0);
        rst_n = 1'b1;
        run_free(100);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule